// File: doc/BRIEF.md
# Indirect Channel Configuration Register Port

This block gives a host access to two banks of per-channel configuration entries through only two I/O locations. A byte-wide pointer location picks a channel and an entry index and also carries a few bus-behaviour control bits. A word-wide data location then reads or writes the entry that the pointer selects. When the pointer's step bit is set, the index advances after every data access. This lets software walk through a whole bank with repeated accesses to the data location.

Each channel bank holds seven entries: a command block base, a general configuration byte, a read-ahead count split over two entries (which also hold read-ahead, FIFO-clear and fast-timing controls), a control block base, and two timing bytes. Some entries are write-only. Several entries come out of reset with non-zero values that differ between the channels. The decoded fields of both channels are driven continuously on output ports. A FIFO-clear request is issued as a one-cycle pulse.

The host side is a plain select/read/write/data interface. Read data is combinational while the read strobe is high. Writes and index steps take effect at the clock edge. The reset input is asynchronous and active-low, and the block releases it synchronously.

Top module: `chan_cfg_port`

## Requirements
- R1: After reset the pointer reads 0x50, meaning step off, posted wait on, burst enabled, medium select timing, channel 0 and index 0. Channel 0 holds command base 0x1F0, control base 0x3F6, general byte 0x01, data timing 0xF5 and command timing 0xDE. Channel 1 holds 0x170, 0x376, 0x01, 0xF5 and 0xDE. Both channels start with read-ahead count 0, read-ahead off and fast timing off.
- R2: A write to the pointer location (sel=1) stores wdata[7:0]. A pointer read returns the stored byte in rdata[7:0], with bit5 read as 0 and the upper byte 0. post_wait_o follows pointer bit6, burst_off_o follows bit5 and devsel_med_o follows bit4.
- R3: The data location (sel=0) writes the entry picked by pointer bit3 (channel) and bits 2..0 (index). Index 0 is the 16-bit command base and index 4 is the 16-bit control base. Both read back in full. The other channel is left unchanged.
- R4: Index 1 stores wdata[7:0] as the general byte on gen_cfg_o. A read returns it with bit2 forced to 0, because bit2 is write-only.
- R5: Index 2 sets read-ahead count bits 7..0. Index 3 sets count bits 9..8 from wdata[1:0], read-ahead enable from bit7 and fast timing from bit4. Index 2 and index 3 both read as 0.
- R6: A write to index 3 with wdata[6]=1 drives fifo_clr_o of that channel high for exactly the next cycle. The bit is not stored.
- R7: Index 5 (data timing) and index 6 (command timing) store wdata[7:0]. They read back zero-extended.
- R8: Index 7 reads 0, and a write to it changes no entry of either channel.
- R9: When pointer bit7 is 1, each data read or data write increments the index, wrapping from 7 to 0, while bits 7..3 are kept. When bit7 is 0 the index stays where it is.
- R10: rdata is valid in the same cycle as rd and is 0 when rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | 1 = pointer location, 0 = data location |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data |
| post_wait_o | output | 1 | Posted write with one wait state |
| burst_off_o | output | 1 | Master burst disabled |
| devsel_med_o | output | 1 | Medium select timing |
| cmd_base_o | output | 32 | Command bases, channel 1 in the upper half |
| ctl_base_o | output | 32 | Control bases |
| gen_cfg_o | output | 16 | General bytes |
| ra_count_o | output | 20 | 10-bit read-ahead counts |
| ra_enable_o | output | 2 | Read-ahead enables |
| mode4_en_o | output | 2 | Fast timing enables |
| fifo_clr_o | output | 2 | FIFO-clear pulses |
| data_tim_o | output | 16 | Data timing bytes |
| cmd_tim_o | output | 16 | Command timing bytes |

## Verification
The bench builds the block with its default parameters: 16-bit data and the two channels' standard reset bases and timing bytes. The reset check therefore sees distinct values on each channel and can detect swapped defaults. Random pointer bytes reach every index on both channels, including index 7, with the step bit both on and off. Directed sequences force the 7-to-0 wrap and back-to-back FIFO-clear writes.

// File: rtl/chan_cfg_pkg.sv
package chan_cfg_pkg;
  localparam int unsigned IDX_W = 3;
  localparam logic [IDX_W-1:0] IX_CMD  = 3'd0;
  localparam logic [IDX_W-1:0] IX_GEN  = 3'd1;
  localparam logic [IDX_W-1:0] IX_RALO = 3'd2;
  localparam logic [IDX_W-1:0] IX_RAHI = 3'd3;
  localparam logic [IDX_W-1:0] IX_CTL  = 3'd4;
  localparam logic [IDX_W-1:0] IX_DTIM = 3'd5;
  localparam logic [IDX_W-1:0] IX_CTIM = 3'd6;
  // pointer bit positions
  localparam int unsigned PB_STEP  = 7;
  localparam int unsigned PB_POST  = 6;
  localparam int unsigned PB_BURST = 5;
  localparam int unsigned PB_DSEL  = 4;
  localparam int unsigned PB_CHAN  = 3;
  localparam logic [7:0]  PTR_RST  = 8'h50;
  localparam int unsigned RA_W     = 10;
endpackage

// File: rtl/chan_cfg_ptr.sv
module chan_cfg_ptr
  import chan_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       ptr_wr_i,
  input  logic [7:0] ptr_wdata_i,
  input  logic       data_acc_i,
  output logic [7:0] ptr_o
);
  logic [7:0] ptr_q, ptr_d;
  logic       ptr_en;

  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = 1'b0;
    if (ptr_wr_i) begin
      ptr_d  = ptr_wdata_i;
      ptr_en = 1'b1;
    end else if (data_acc_i && ptr_q[PB_STEP]) begin
      ptr_d[IDX_W-1:0] = ptr_q[IDX_W-1:0] + 1'b1;
      ptr_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= PTR_RST;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  assert_idx_step_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (data_acc_i && !ptr_wr_i && ptr_q[PB_STEP]) |=>
      (ptr_q[IDX_W-1:0] == $past(ptr_q[IDX_W-1:0]) + 3'd1) && (ptr_q[7:3] == $past(ptr_q[7:3])));

  assert_idx_hold_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (!ptr_wr_i && !ptr_q[PB_STEP]) |=> $stable(ptr_q));
endmodule

// File: rtl/chan_cfg_bank.sv
module chan_cfg_bank
  import chan_cfg_pkg::*;
#(
  parameter int unsigned DW       = 16,
  parameter logic [15:0] CMD_RST  = 16'h01F0,
  parameter logic [15:0] CTL_RST  = 16'h03F6,
  parameter logic [7:0]  GEN_RST  = 8'h01,
  parameter logic [7:0]  DTIM_RST = 8'hF5,
  parameter logic [7:0]  CTIM_RST = 8'hDE
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rd_o,
  output logic [DW-1:0]    cmd_base_o,
  output logic [DW-1:0]    ctl_base_o,
  output logic [7:0]       gen_o,
  output logic [RA_W-1:0]  ra_cnt_o,
  output logic             ra_en_o,
  output logic             mode4_o,
  output logic             fifo_clr_o,
  output logic [7:0]       dtim_o,
  output logic [7:0]       ctim_o
);
  logic [DW-1:0]   cmd_q, cmd_d, ctl_q, ctl_d;
  logic [7:0]      gen_q, gen_d, dt_q, dt_d, ct_q, ct_d;
  logic [RA_W-1:0] ra_q, ra_d;
  logic            ren_q, ren_d, m4_q, m4_d, clr_q, clr_d;

  always_comb begin
    cmd_d = cmd_q; ctl_d = ctl_q; gen_d = gen_q; dt_d = dt_q; ct_d = ct_q;
    ra_d = ra_q; ren_d = ren_q; m4_d = m4_q;
    clr_d = 1'b0;
    if (wr_en_i) begin
      case (idx_i)
        IX_CMD:  cmd_d = wdata_i;
        IX_GEN:  gen_d = wdata_i[7:0];
        IX_RALO: ra_d[7:0] = wdata_i[7:0];
        IX_RAHI: begin
          ra_d[RA_W-1:8] = wdata_i[RA_W-9:0];
          ren_d = wdata_i[7];
          m4_d  = wdata_i[4];
          clr_d = wdata_i[6];
        end
        IX_CTL:  ctl_d = wdata_i;
        IX_DTIM: dt_d = wdata_i[7:0];
        IX_CTIM: ct_d = wdata_i[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= CMD_RST; ctl_q <= CTL_RST; gen_q <= GEN_RST;
      dt_q <= DTIM_RST; ct_q <= CTIM_RST;
      ra_q <= '0; ren_q <= 1'b0; m4_q <= 1'b0; clr_q <= 1'b0;
    end else begin
      clr_q <= clr_d;
      if (wr_en_i) begin
        cmd_q <= cmd_d; ctl_q <= ctl_d; gen_q <= gen_d;
        dt_q <= dt_d; ct_q <= ct_d;
        ra_q <= ra_d; ren_q <= ren_d; m4_q <= m4_d;
      end
    end
  end

  always_comb begin
    case (idx_i)
      IX_CMD:  rd_o = cmd_q;
      IX_GEN:  rd_o = DW'(gen_q & 8'hFB);
      IX_CTL:  rd_o = ctl_q;
      IX_DTIM: rd_o = DW'(dt_q);
      IX_CTIM: rd_o = DW'(ct_q);
      default: rd_o = '0;
    endcase
  end

  assign cmd_base_o = cmd_q;
  assign ctl_base_o = ctl_q;
  assign gen_o      = gen_q;
  assign ra_cnt_o   = ra_q;
  assign ra_en_o    = ren_q;
  assign mode4_o    = m4_q;
  assign fifo_clr_o = clr_q;
  assign dtim_o     = dt_q;
  assign ctim_o     = ct_q;

  assert_idx7_ignored_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (!wr_en_i || idx_i == 3'd7) |=>
      $stable(cmd_q) && $stable(ctl_q) && $stable(gen_q) && $stable(ra_q) &&
      $stable(ren_q) && $stable(m4_q) && $stable(dt_q) && $stable(ct_q));

  assert_fifo_single_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (fifo_clr_o && !(wr_en_i && idx_i == IX_RAHI && wdata_i[6])) |=> !fifo_clr_o);

  assert_wo_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (idx_i == IX_RALO || idx_i == IX_RAHI) |-> (rd_o == '0));
endmodule

// File: rtl/chan_cfg_port.sv
module chan_cfg_port
  import chan_cfg_pkg::*;
#(
  parameter int unsigned DW        = 16,
  parameter logic [15:0] CMD_RST0  = 16'h01F0,
  parameter logic [15:0] CMD_RST1  = 16'h0170,
  parameter logic [15:0] CTL_RST0  = 16'h03F6,
  parameter logic [15:0] CTL_RST1  = 16'h0376,
  parameter logic [7:0]  GEN_RST   = 8'h01,
  parameter logic [7:0]  DTIM_RST  = 8'hF5,
  parameter logic [7:0]  CTIM_RST  = 8'hDE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  output logic              post_wait_o,
  output logic              burst_off_o,
  output logic              devsel_med_o,
  output logic [2*DW-1:0]   cmd_base_o,
  output logic [2*DW-1:0]   ctl_base_o,
  output logic [15:0]       gen_cfg_o,
  output logic [2*RA_W-1:0] ra_count_o,
  output logic [1:0]        ra_enable_o,
  output logic [1:0]        mode4_en_o,
  output logic [1:0]        fifo_clr_o,
  output logic [15:0]       data_tim_o,
  output logic [15:0]       cmd_tim_o
);
  localparam int unsigned NCH = 2;

  logic rst_q1, rst_q2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0; rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1; rst_q2 <= rst_q1;
    end
  end

  logic [7:0] ptr;
  logic       data_acc, data_wr;
  logic [DW-1:0] bank_rd [NCH];

  assign data_acc = !host_sel && (host_rd || host_wr);
  assign data_wr  = !host_sel && host_wr;

  chan_cfg_ptr u_ptr (
    .clk(clk), .rst_ni(rst_q2), .ptr_wr_i(host_sel && host_wr),
    .ptr_wdata_i(host_wdata[7:0]), .data_acc_i(data_acc), .ptr_o(ptr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chan_cfg_bank #(
      .DW(DW),
      .CMD_RST(c == 0 ? CMD_RST0 : CMD_RST1),
      .CTL_RST(c == 0 ? CTL_RST0 : CTL_RST1),
      .GEN_RST(GEN_RST), .DTIM_RST(DTIM_RST), .CTIM_RST(CTIM_RST)
    ) u_bank (
      .clk(clk), .rst_ni(rst_q2),
      .wr_en_i(data_wr && (ptr[PB_CHAN] == 1'(c))),
      .idx_i(ptr[IDX_W-1:0]), .wdata_i(host_wdata),
      .rd_o(bank_rd[c]),
      .cmd_base_o(cmd_base_o[c*DW +: DW]),
      .ctl_base_o(ctl_base_o[c*DW +: DW]),
      .gen_o(gen_cfg_o[c*8 +: 8]),
      .ra_cnt_o(ra_count_o[c*RA_W +: RA_W]),
      .ra_en_o(ra_enable_o[c]),
      .mode4_o(mode4_en_o[c]),
      .fifo_clr_o(fifo_clr_o[c]),
      .dtim_o(data_tim_o[c*8 +: 8]),
      .ctim_o(cmd_tim_o[c*8 +: 8])
    );
  end

  always_comb begin
    host_rdata = '0;
    if (host_rd) begin
      if (host_sel) host_rdata = DW'(ptr & 8'hDF);
      else          host_rdata = bank_rd[ptr[PB_CHAN]];
    end
  end

  assign post_wait_o  = ptr[PB_POST];
  assign burst_off_o  = ptr[PB_BURST];
  assign devsel_med_o = ptr[PB_DSEL];

  always_comb begin
    if (rst_q2 && host_rd && !host_sel && ptr[IDX_W-1:0] == 3'd7)
      assert_idx7_read_R8: assert (host_rdata == '0);
    if (rst_q2 && !host_rd)
      assert_idle_rdata_R10: assert (host_rdata == '0);
  end

  assert_ptr_bit5_read_R2: assert property (@(posedge clk) disable iff (!rst_q2)
    (host_rd && host_sel) |-> (host_rdata[5] == 1'b0 && host_rdata[DW-1:8] == '0));
endmodule

// File: tb/chan_cfg_port_test.sv
module chan_cfg_port_test;
  logic clk = 1'b0;
  logic rst_n;
  logic sel, rd, wr;
  logic [15:0] wdata, rdata;
  logic pw, bo, dm;
  logic [31:0] cmd_o, ctl_o;
  logic [15:0] gen_o, dt_o, ct_o;
  logic [19:0] ra_o;
  logic [1:0] ren_o, m4_o, clr_o;

  always #2 clk = ~clk;

  chan_cfg_port uut (
    .clk(clk), .rst_n(rst_n), .host_sel(sel), .host_rd(rd), .host_wr(wr),
    .host_wdata(wdata), .host_rdata(rdata), .post_wait_o(pw), .burst_off_o(bo),
    .devsel_med_o(dm), .cmd_base_o(cmd_o), .ctl_base_o(ctl_o), .gen_cfg_o(gen_o),
    .ra_count_o(ra_o), .ra_enable_o(ren_o), .mode4_en_o(m4_o), .fifo_clr_o(clr_o),
    .data_tim_o(dt_o), .cmd_tim_o(ct_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // model
  logic [7:0]  m_ptr;
  logic [15:0] m_cmd [2], m_ctl [2];
  logic [7:0]  m_gen [2], m_dt [2], m_ct [2];
  logic [9:0]  m_ra [2];
  logic        m_ren [2], m_m4 [2], m_clr [2];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input logic s);
    logic c;
    c = m_ptr[3];
    if (s) return {8'h00, m_ptr & 8'hDF};
    case (m_ptr[2:0])
      3'd0: return m_cmd[c];
      3'd1: return {8'h00, m_gen[c] & 8'hFB};
      3'd4: return m_ctl[c];
      3'd5: return {8'h00, m_dt[c]};
      3'd6: return {8'h00, m_ct[c]};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_reset();
    m_ptr = 8'h50;
    m_cmd[0] = 16'h01F0; m_cmd[1] = 16'h0170;
    m_ctl[0] = 16'h03F6; m_ctl[1] = 16'h0376;
    for (int c = 0; c < 2; c++) begin
      m_gen[c] = 8'h01; m_dt[c] = 8'hF5; m_ct[c] = 8'hDE;
      m_ra[c] = '0; m_ren[c] = 0; m_m4[c] = 0; m_clr[c] = 0;
    end
  endtask

  task automatic model_step(input logic s, input logic r, input logic w, input logic [15:0] d);
    logic c;
    c = m_ptr[3];
    m_clr[0] = 0; m_clr[1] = 0;
    if (s && w) m_ptr = d[7:0];
    else if (!s && (r || w)) begin
      if (w) case (m_ptr[2:0])
        3'd0: m_cmd[c] = d;
        3'd1: m_gen[c] = d[7:0];
        3'd2: m_ra[c][7:0] = d[7:0];
        3'd3: begin m_ra[c][9:8] = d[1:0]; m_ren[c] = d[7]; m_m4[c] = d[4]; m_clr[c] = d[6]; end
        3'd4: m_ctl[c] = d;
        3'd5: m_dt[c] = d[7:0];
        3'd6: m_ct[c] = d[7:0];
        default: ;
      endcase
      if (m_ptr[7]) m_ptr[2:0] = m_ptr[2:0] + 3'd1;
    end
  endtask

  task automatic check_outs();
    chk({pw, bo, dm} == {m_ptr[6], m_ptr[5], m_ptr[4]}, "R2 ctrl bits", {pw, bo, dm}, {m_ptr[6], m_ptr[5], m_ptr[4]});
    for (int c = 0; c < 2; c++) begin
      chk(cmd_o[c*16 +: 16] == m_cmd[c], "R3 cmd base", cmd_o[c*16 +: 16], m_cmd[c]);
      chk(ctl_o[c*16 +: 16] == m_ctl[c], "R3 ctl base", ctl_o[c*16 +: 16], m_ctl[c]);
      chk(gen_o[c*8 +: 8] == m_gen[c], "R4 general", gen_o[c*8 +: 8], m_gen[c]);
      chk(ra_o[c*10 +: 10] == m_ra[c], "R5 ra count", ra_o[c*10 +: 10], m_ra[c]);
      chk({ren_o[c], m4_o[c]} == {m_ren[c], m_m4[c]}, "R5 ra/mode4", {ren_o[c], m4_o[c]}, {m_ren[c], m_m4[c]});
      chk(clr_o[c] == m_clr[c], "R6 fifo pulse", clr_o[c], m_clr[c]);
      chk(dt_o[c*8 +: 8] == m_dt[c], "R7 data timing", dt_o[c*8 +: 8], m_dt[c]);
      chk(ct_o[c*8 +: 8] == m_ct[c], "R7 cmd timing", ct_o[c*8 +: 8], m_ct[c]);
    end
  endtask

  // called at a negedge
  task automatic op(input logic s, input logic r, input logic w, input logic [15:0] d);
    logic [15:0] e;
    sel = s; rd = r; wr = w; wdata = d;
    #1;
    if (r) begin
      e = exp_read(s);
      chk(rdata == e, s ? "R2 ptr read" : (m_ptr[2:0] == 3'd7 ? "R8 idx7 read" : "R10 data read"), rdata, e);
    end else chk(rdata == 16'h0, "R10 idle rdata", rdata, 16'h0);
    @(posedge clk);
    model_step(s, r, w, d);
    @(negedge clk);
    sel = 0; rd = 0; wr = 0; wdata = '0;
    check_outs();
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [15:0] r16;
    logic [7:0] pb;
    seed = 32'd1234;
    void'($urandom(seed));
    sel = 0; rd = 0; wr = 0; wdata = '0;
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check_outs();
    op(1, 1, 0, 0);
    chk(m_ptr == 8'h50, "R1 ptr reset", m_ptr, 8'h50);
    // R1 reset read of each channel through data port
    for (int c = 0; c < 2; c++) begin
      op(1, 0, 1, {8'h0, 8'h50 | 8'(c << 3)});
      op(0, 1, 0, 0);
      op(1, 0, 1, {8'h0, 8'h54 | 8'(c << 3)});
      op(0, 1, 0, 0);
    end
    // R2 bit5 write-only
    op(1, 0, 1, 16'hFF2F);
    op(1, 1, 0, 0);
    // R9 autoinc walk and wrap 7->0, channel 1
    op(1, 0, 1, 16'h00C8);
    for (int i = 0; i < 9; i++) op(0, 0, 1, 16'hA500 + 16'(i));
    for (int i = 0; i < 9; i++) op(0, 1, 0, 0);
    // R6 back-to-back fifo clear, R8 idx7 write ignored
    op(1, 0, 1, 16'h0053);
    op(0, 0, 1, 16'h00C3);
    op(0, 0, 1, 16'h0040);
    op(0, 0, 1, 16'h0000);
    op(1, 0, 1, 16'h005F);
    op(0, 0, 1, 16'hFFFF);
    op(0, 1, 0, 0);
    // random mix
    for (int n = 0; n < 1500; n++) begin
      r16 = 16'($urandom);
      case ($urandom % 10)
        0, 1, 2: begin pb = 8'($urandom); op(1, 0, 1, {r16[15:8], pb}); end
        3: op(1, 1, 0, 0);
        4, 5, 6: op(0, 0, 1, r16);
        default: op(0, 1, 0, 0);
      endcase
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule